// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous Memory

This block is a single-clock synchronous memory on one shared, bidirectional data bus. It has an active-low select and an active-low write strobe. Reads are pipelined. The address taken on one rising edge delivers its word on the bus for the whole of the next clock period.

Writes are split in time. The address and the write strobe are taken on one edge, and the data word is taken from the bus on the following edge. The host therefore needs to turn the bus around only once when it moves from reading to writing. Only the read issued directly before a write gives up its bus slot. Every earlier read is delivered in full.

The block keeps the address of the write in flight and commits it when its data arrives. A read that is captured on that same data edge and targets the same word gets the arriving data through a forwarding path. Deselect cycles are idle and never cancel a write whose address was already taken.

Top module: `lw_sram`

## Requirements
- R1: While reset is high, and in the first bus slot after reset is released, the block drives nothing onto the data bus (all bits high-impedance), and no write is pending.
- R2: A read is captured on edge N (select low, write strobe high). The block drives that word onto the bus from edge N+1 until edge N+2, so reads on consecutive edges stream one word per clock.
- R3: A write is captured on edge N (select low, write strobe low, address valid). The word present on the bus at edge N+1 is stored at that address. The block does not drive the bus between edges N and N+1.
- R4: A read captured on edge N is followed by a write captured on edge N+1. The read's slot (edge N+1 to N+2) stays high-impedance, and reads captured before edge N are still delivered intact.
- R5: A read captured on the data edge of a pending write to the same address returns the word taken from the bus on that edge.
- R6: Writes captured on consecutive edges are each stored. The data of one write is accepted on the edge that captures the next write address.
- R7: A cycle with select high is idle. The write strobe and address are ignored, nothing is driven in the corresponding bus slot, and a write whose address was taken on the previous edge still commits.
- R8: A read captured on the data edge of a pending write to a different address returns that address's stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high makes the cycle idle |
| we_n | input | 1 | Active-low write strobe; high selects a read |
| addr | input | AW | Word address |
| dq | inout | DW | Shared data bus: write data in, read data out |

## Verification
A full fill using back-to-back writes followed by a streaming read sweep separates correct two-phase write capture and one-word-per-clock read timing from an off-by-one pipeline. Three directed patterns each isolate one corner. A read placed just before a write confirms that exactly one slot is blanked. A write followed at once by a read of the same word, and then of another word, distinguishes forwarded data from stale array contents. A deselect placed on a write's data edge confirms that the write still commits and the deselected address stays unchanged. A long pseudo-random mix of idle, read and write cycles over all sixteen words is then compared, slot by slot, against an arithmetic reference array. This mix exercises every ordering of the three commands.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic sel_n, input logic wr_n);
    if (sel_n)     return CMD_IDLE;
    else if (wr_n) return CMD_READ;
    else           return CMD_WRITE;
  endfunction

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          wr_now,
  output logic          rd_vld_q,
  output logic          fwd_hit_q,
  output logic          pend_vld_q,
  output logic [AW-1:0] pend_addr_q
);

  cmd_e cmd;

  always_comb begin
    cmd    = decode_cmd(cs_n, we_n);
    wr_now = (cmd == CMD_WRITE);
  end

  // Pending write: address held one cycle until its data edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      rd_vld_q    <= 1'b0;
      fwd_hit_q   <= 1'b0;
    end else begin
      pend_vld_q <= (cmd == CMD_WRITE);
      if (cmd == CMD_WRITE) pend_addr_q <= addr;
      rd_vld_q   <= (cmd == CMD_READ);
      // The array read at this edge misses the commit happening at the same edge.
      fwd_hit_q  <= (cmd == CMD_READ) && pend_vld_q && (addr == pend_addr_q);
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port shape with registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lw_sram_dout.sv
module lw_sram_dout #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_vld_q,
  input  logic          fwd_hit_q,
  input  logic          wr_now,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout_q,
  output logic          oe_q
);

  logic [DW-1:0] fwd_data_q;

  // Bus word captured every edge; used only when the read hit a pending write.
  always_ff @(posedge clk) begin
    fwd_data_q <= dq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      // A write captured now means the host owns the bus next cycle.
      oe_q   <= rd_vld_q && !wr_now;
      dout_q <= fwd_hit_q ? fwd_data_q : rdata;
    end
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] dq
);

  logic          wr_now;
  logic          rd_vld_q;
  logic          fwd_hit_q;
  logic          pend_vld_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dout_q;
  logic          dq_oe;
  logic [DW-1:0] dq_in;

  assign dq_in = dq;
  assign dq    = dq_oe ? dout_q : {DW{1'bz}};

  lw_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .we_n        (we_n),
    .addr        (addr),
    .wr_now      (wr_now),
    .rd_vld_q    (rd_vld_q),
    .fwd_hit_q   (fwd_hit_q),
    .pend_vld_q  (pend_vld_q),
    .pend_addr_q (pend_addr_q)
  );

  lw_sram_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (pend_vld_q),
    .waddr (pend_addr_q),
    .wdata (dq_in),
    .raddr (addr),
    .rdata (rdata)
  );

  lw_sram_dout #(.DW(DW)) u_dout (
    .clk       (clk),
    .rst       (rst),
    .rd_vld_q  (rd_vld_q),
    .fwd_hit_q (fwd_hit_q),
    .wr_now    (wr_now),
    .dq_in     (dq_in),
    .rdata     (rdata),
    .dout_q    (dout_q),
    .oe_q      (dq_oe)
  );

endmodule

// File: rtl/lw_sram_checker.sv
module lw_sram_checker #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq,
  input logic          oe
);

  logic          c_rd;
  logic          c_pend;
  logic [AW-1:0] c_paddr;
  logic          c_hit;
  logic [DW-1:0] c_bus;
  logic          wr_cmd;

  assign wr_cmd = !cs_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_rd    <= 1'b0;
      c_pend  <= 1'b0;
      c_paddr <= '0;
      c_hit   <= 1'b0;
      c_bus   <= '0;
    end else begin
      c_rd   <= !cs_n && we_n;
      c_pend <= wr_cmd;
      if (wr_cmd) c_paddr <= addr;
      c_hit  <= !cs_n && we_n && c_pend && (addr == c_paddr);
      c_bus  <= dq;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !oe);

  assert_read_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (c_rd && !wr_cmd) |=> oe);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
    (c_rd && wr_cmd) |=> !oe);

  assert_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (c_hit && !wr_cmd) |=> (dq == $past(c_bus)));

  assert_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
    !c_rd |=> !oe);

endmodule

bind lw_sram lw_sram_checker #(.AW(AW), .DW(DW)) u_lw_sram_checker (
  .clk  (clk),
  .rst  (rst),
  .cs_n (cs_n),
  .we_n (we_n),
  .addr (addr),
  .dq   (dq),
  .oe   (dq_oe)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cs_n;
  logic          we_n;
  logic [AW-1:0] addr;
  logic          tb_oe;
  logic [DW-1:0] tb_data;
  wire  [DW-1:0] dq;

  assign dq = tb_oe ? tb_data : {DW{1'bz}};

  always #10 clk = ~clk;

  lw_sram #(.AW(AW), .DW(DW)) i_lw_sram (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .we_n (we_n),
    .addr (addr),
    .dq   (dq)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  logic          s1_oe, s2_oe;
  logic [DW-1:0] s1_val, s2_val;
  string         s1_tag, s2_tag;
  string         rd_tag;
  logic          pw_vld;
  logic [AW-1:0] pw_addr;
  logic [DW-1:0] pw_data;
  int            checks = 0;
  int            fails  = 0;
  logic [15:0]   lfsr;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus slot: called just after a falling edge, returns at the next one.
  task automatic cyc(input logic c_n, input logic w_n, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    if (pw_vld) begin
      tb_oe   = 1'b1;
      tb_data = pw_data;
      ref_mem[pw_addr] = pw_data;
    end else begin
      tb_oe = 1'b0;
    end
    #1;
    if (s1_oe)      check(s1_tag, dq, s1_val);
    else if (tb_oe) check("R3", dq, tb_data);
    else            check(s1_tag, dq, {DW{1'bz}});
    s1_oe  = s2_oe;
    s1_val = s2_val;
    s1_tag = s2_tag;
    s2_oe  = 1'b0;
    s2_tag = rst ? "R1" : (c_n ? "R7" : "R6");
    cs_n = c_n;
    we_n = w_n;
    addr = a;
    if (!rst && !c_n && !w_n && s1_oe) begin
      s1_oe  = 1'b0;
      s1_tag = "R4";
    end
    if (!rst && !c_n && w_n) begin
      s2_oe  = 1'b1;
      s2_val = ref_mem[a];
      if (pw_vld) s2_tag = (pw_addr == a) ? "R5" : "R8";
      else        s2_tag = rd_tag;
    end
    pw_vld  = !rst && !c_n && !w_n;
    pw_addr = a;
    pw_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2: watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; we_n = 1'b1; addr = '0;
    tb_oe = 1'b0; tb_data = '0;
    s1_oe = 1'b0; s2_oe = 1'b0; s1_val = '0; s2_val = '0;
    s1_tag = "R1"; s2_tag = "R1"; rd_tag = "R2";
    pw_vld = 1'b0; pw_addr = '0; pw_data = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    @(negedge clk);
    repeat (3) cyc(1'b1, 1'b1, '0, '0);          // R1: quiet in reset
    rst = 1'b0;
    repeat (2) cyc(1'b1, 1'b0, '0, '0);          // R1/R7: quiet after release

    // R6: fill with back-to-back writes
    for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b0, AW'(a), pat(a));
    cyc(1'b1, 1'b1, '0, '0);
    // R6: stream every word back
    rd_tag = "R6";
    for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b1, AW'(a), '0);
    rd_tag = "R2";
    repeat (2) cyc(1'b1, 1'b1, '0, '0);

    // R2: streaming reads in descending order
    for (int a = DEPTH - 1; a >= 0; a--) cyc(1'b0, 1'b1, AW'(a), '0);
    repeat (2) cyc(1'b1, 1'b1, '0, '0);

    // R4: two reads then a write; only the last read is blanked
    cyc(1'b0, 1'b1, 4'd1, '0);
    cyc(1'b0, 1'b1, 4'd3, '0);
    cyc(1'b0, 1'b0, 4'd5, 8'hA5);
    cyc(1'b0, 1'b1, 4'd5, '0);                   // R5: forwarded
    cyc(1'b1, 1'b1, '0, '0);
    cyc(1'b0, 1'b1, 4'd3, '0);
    repeat (2) cyc(1'b1, 1'b1, '0, '0);

    // R5 / R8: write then read same word, then a different word
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b0, 1'b0, AW'(a), ~pat(a));
      cyc(1'b0, 1'b1, AW'(a), '0);
      cyc(1'b0, 1'b0, AW'(a), pat(a) ^ 8'h5A);
      cyc(1'b0, 1'b1, AW'(a + 1), '0);
      cyc(1'b1, 1'b1, '0, '0);
    end
    repeat (2) cyc(1'b1, 1'b1, '0, '0);

    // R7: deselect with strobe low on a data edge; write still commits
    cyc(1'b0, 1'b0, 4'd2, 8'h3C);
    cyc(1'b1, 1'b0, 4'd9, 8'hFF);
    cyc(1'b0, 1'b1, 4'd2, '0);
    cyc(1'b0, 1'b1, 4'd9, '0);
    repeat (2) cyc(1'b1, 1'b1, '0, '0);

    // Pseudo-random mix of all command orderings
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[1:0] == 2'b00, lfsr[2] | lfsr[3], lfsr[7:4], lfsr[15:8]);
    end
    repeat (3) cyc(1'b1, 1'b1, '0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule